// File: doc/BRIEF.md
# Page-Erase Nonvolatile Memory Controller

This block manages a 512-byte nonvolatile byte store on behalf of a serial-bus front end. The store is modelled as a synthesizable register array, and programming and erasure take timed busy windows. The front end presents one request per cycle: a read, a write or a one-byte command. The controller answers that request in the same cycle with an acknowledge, or it refuses it. Refused requests have no effect. The front end turns a refusal into a bus not-acknowledge.

The store follows flash-like rules. A byte can be programmed only when it is blank, which means it holds 0xFF. To clear programmed bytes, the whole 32-byte page that contains them is erased. An erase needs two things: an enable bit set in a small configuration register, and a dedicated command byte. The page erased is the page of the most recent accepted store write. While a program or erase window runs, the block reports busy and refuses all traffic.

Top module: `pgerase_nvm`

## Requirements
- R1: After reset, busy and the error flag are low, the configuration register reads 0x00, and every store byte reads 0xFF.
- R2: The operation codes are 0 = read, 1 = write and 2 = command. A read or write is acknowledged only at store addresses 0xF800 to 0xF9FF or at the configuration address 0x0090. Other addresses, and operation code 3, are refused and have no effect.
- R3: An accepted read raises rdValid for one cycle in the next cycle. rdData then holds the addressed byte, or the configuration register.
- R4: An accepted write to a store byte that holds 0xFF raises busy from the next cycle for exactly WR_CYCLES cycles. After busy falls, the byte holds the written data.
- R5: An accepted write to a store byte that is not 0xFF leaves the byte unchanged and does not raise busy. It sets progError in the next cycle. progError stays high until reset.
- R6: Command 0xFE with configuration bit 3 set raises busy for exactly ERASE_CYCLES cycles. After that, all 32 bytes of the page that holds the latest accepted store write read 0xFF. The page number is store offset bits 8:5. Other pages are unchanged.
- R7: A command is acknowledged but has no effect if it is 0xFE while configuration bit 3 is clear, or if it is any other byte value.
- R8: While busy is high, every request is refused and has no effect. Busy falls only when its timer expires.
- R9: A write to address 0x0090 loads the configuration register without raising busy. A read at that address returns the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A request is presented this cycle |
| reqOp | input | 2 | Operation: 0 read, 1 write, 2 command |
| reqAddr | input | 16 | Byte address for a read or write |
| reqData | input | 8 | Write data, or the command byte |
| reqAck | output | 1 | The request is accepted in this cycle |
| rdValid | output | 1 | Read data is valid |
| rdData | output | 8 | Read data |
| busy | output | 1 | A program or erase window is running |
| progError | output | 1 | Sticky flag: a write hit a non-blank byte |

## Verification
The bench targets these corner cases:
- **Rewrite of a programmed byte.** A design that overwrote the byte or ORed in the new data would return the new value on read-back, not the old one.
- **Erase command with the enable bit clear.** A design that ignored the enable bit would wipe a page.
- **Page choice for the erase.** A design that took the page from the wrong write, or from the wrong address bits, would blank a neighbouring page and leave the target page intact.
- **Requests during a busy window.** Requests sent while busy must be refused and must not reach the store. A later read of a blank byte would expose a write that slipped in.
- **Busy window length.** An off-by-one in the timer shows up in the measured busy length.
- **Address range edges.** The two ends of the store range are checked, along with the addresses just outside them.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_CMD   = 2'd2
  } nvmOp_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_PROG  = 2'd1,
    S_ERASE = 2'd2
  } nvmState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic cfgWr;        // load configuration register
    logic latchWr;      // capture store write: pending byte and page
    logic commitWr;     // program pending byte
    logic commitErase;  // blank latched page
    logic rdStore;      // capture store byte for read
    logic rdCfg;        // capture configuration register for read
    logic setErr;       // set sticky error
  } nvmStrobe_t;

  localparam logic [7:0] BLANK_BYTE = 8'hFF;

endpackage

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int          DEPTH_BYTES  = 512,
  parameter logic [15:0] BASE_ADDR    = 16'hF800,
  parameter logic [15:0] CFG_ADDR     = 16'h0090,
  parameter logic [7:0]  ERASE_CMD    = 8'hFE,
  parameter int          WR_CYCLES    = 16,
  parameter int          ERASE_CYCLES = 64,
  localparam int         IDX_W        = $clog2(DEPTH_BYTES),
  localparam int         MAX_CYC      = (WR_CYCLES > ERASE_CYCLES) ? WR_CYCLES : ERASE_CYCLES,
  localparam int         TMR_W        = $clog2(MAX_CYC + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [15:0]      reqAddr,
  input  logic [7:0]       reqData,
  input  logic             byteBlank,
  input  logic             eraseEn,
  output logic             reqAck,
  output logic             busy,
  output logic [IDX_W-1:0] byteIdx,
  output nvmStrobe_t       strobe
);

  nvmState_t        state, stateNext;
  logic [TMR_W-1:0] timer, timerNext;
  logic [15:0]      offset;
  logic             inStore, isCfg, opOk;

  // address decode; below-base addresses wrap to large offsets
  always_comb begin
    offset  = reqAddr - BASE_ADDR;
    inStore = (offset < 16'(DEPTH_BYTES));
    isCfg   = (reqAddr == CFG_ADDR);
    byteIdx = offset[IDX_W-1:0];
    unique case (reqOp)
      OP_READ, OP_WRITE: opOk = inStore || isCfg;
      OP_CMD:            opOk = 1'b1;
      default:           opOk = 1'b0;
    endcase
  end

  assign busy   = (state != S_IDLE);
  assign reqAck = reqValid && !busy && opOk;

  always_comb begin
    stateNext = state;
    timerNext = timer;
    strobe    = '0;
    unique case (state)
      S_IDLE: begin
        if (reqAck) begin
          unique case (reqOp)
            OP_READ: begin
              strobe.rdStore = inStore;
              strobe.rdCfg   = !inStore;
            end
            OP_WRITE: begin
              if (inStore) begin
                strobe.latchWr = 1'b1;
                if (byteBlank) begin
                  stateNext = S_PROG;
                  timerNext = TMR_W'(WR_CYCLES - 1);
                end else begin
                  strobe.setErr = 1'b1;
                end
              end else begin
                strobe.cfgWr = 1'b1;
              end
            end
            default: begin
              if (reqData == ERASE_CMD && eraseEn) begin
                stateNext = S_ERASE;
                timerNext = TMR_W'(ERASE_CYCLES - 1);
              end
            end
          endcase
        end
      end
      S_PROG, S_ERASE: begin
        if (timer == '0) begin
          stateNext          = S_IDLE;
          strobe.commitWr    = (state == S_PROG);
          strobe.commitErase = (state == S_ERASE);
        end else begin
          timerNext = timer - 1'b1;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      timer <= '0;
    end else begin
      state <= stateNext;
      timer <= timerNext;
    end
  end

endmodule

// File: rtl/nvm_datapath.sv
module nvm_datapath
  import nvm_pkg::*;
#(
  parameter int DEPTH_BYTES  = 512,
  parameter int PAGE_BYTES   = 32,
  parameter int ERASE_EN_BIT = 3,
  localparam int IDX_W       = $clog2(DEPTH_BYTES),
  localparam int PAGES       = DEPTH_BYTES / PAGE_BYTES,
  localparam int PAGE_W      = $clog2(PAGES),
  localparam int PG_SHIFT    = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  nvmStrobe_t       strobe,
  input  logic [IDX_W-1:0] byteIdx,
  input  logic [7:0]       reqData,
  output logic             byteBlank,
  output logic             eraseEn,
  output logic             rdValid,
  output logic [7:0]       rdData,
  output logic             progError
);

  logic [7:0]        mem [DEPTH_BYTES];
  logic [7:0]        cfgReg;
  logic [IDX_W-1:0]  pendIdx;
  logic [7:0]        pendData;
  logic [PAGE_W-1:0] pageLatch;
  logic [7:0]        curByte;

  assign curByte   = mem[byteIdx];
  assign byteBlank = (curByte == BLANK_BYTE);
  assign eraseEn   = cfgReg[ERASE_EN_BIT];

  // store array, one page-match per byte for erasure
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH_BYTES; i++) mem[i] <= BLANK_BYTE;
    end else begin
      if (strobe.commitWr) mem[pendIdx] <= pendData;
      if (strobe.commitErase) begin
        for (int i = 0; i < DEPTH_BYTES; i++) begin
          if (PAGE_W'(i >> PG_SHIFT) == pageLatch) mem[i] <= BLANK_BYTE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg    <= '0;
      pendIdx   <= '0;
      pendData  <= '0;
      pageLatch <= '0;
      rdValid   <= 1'b0;
      rdData    <= '0;
      progError <= 1'b0;
    end else begin
      if (strobe.cfgWr) cfgReg <= reqData;
      if (strobe.latchWr) begin
        pendIdx   <= byteIdx;
        pendData  <= reqData;
        pageLatch <= byteIdx[IDX_W-1:PG_SHIFT];
      end
      rdValid <= strobe.rdStore || strobe.rdCfg;
      if (strobe.rdStore)    rdData <= curByte;
      else if (strobe.rdCfg) rdData <= cfgReg;
      if (strobe.setErr) progError <= 1'b1;
    end
  end

endmodule

// File: rtl/pgerase_nvm.sv
module pgerase_nvm
  import nvm_pkg::*;
#(
  parameter int          DEPTH_BYTES  = 512,
  parameter int          PAGE_BYTES   = 32,
  parameter logic [15:0] BASE_ADDR    = 16'hF800,
  parameter logic [15:0] CFG_ADDR     = 16'h0090,
  parameter int          ERASE_EN_BIT = 3,
  parameter logic [7:0]  ERASE_CMD    = 8'hFE,
  parameter int          WR_CYCLES    = 16,
  parameter int          ERASE_CYCLES = 64,
  localparam int         IDX_W        = $clog2(DEPTH_BYTES)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  input  logic [15:0] reqAddr,
  input  logic [7:0]  reqData,
  output logic        reqAck,
  output logic        rdValid,
  output logic [7:0]  rdData,
  output logic        busy,
  output logic        progError
);

  nvmStrobe_t       strobe;
  logic [IDX_W-1:0] byteIdx;
  logic             byteBlank, eraseEn;

  nvm_ctrl #(
    .DEPTH_BYTES (DEPTH_BYTES),
    .BASE_ADDR   (BASE_ADDR),
    .CFG_ADDR    (CFG_ADDR),
    .ERASE_CMD   (ERASE_CMD),
    .WR_CYCLES   (WR_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .byteBlank(byteBlank),
    .eraseEn  (eraseEn),
    .reqAck   (reqAck),
    .busy     (busy),
    .byteIdx  (byteIdx),
    .strobe   (strobe)
  );

  nvm_datapath #(
    .DEPTH_BYTES (DEPTH_BYTES),
    .PAGE_BYTES  (PAGE_BYTES),
    .ERASE_EN_BIT(ERASE_EN_BIT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .byteIdx  (byteIdx),
    .reqData  (reqData),
    .byteBlank(byteBlank),
    .eraseEn  (eraseEn),
    .rdValid  (rdValid),
    .rdData   (rdData),
    .progError(progError)
  );

endmodule

// File: rtl/nvm_checker.sv
module nvm_checker #(
  parameter int          DEPTH_BYTES  = 512,
  parameter logic [15:0] BASE_ADDR    = 16'hF800,
  parameter logic [15:0] CFG_ADDR     = 16'h0090,
  parameter int          WR_CYCLES    = 16,
  parameter int          ERASE_CYCLES = 64
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [1:0]  reqOp,
  input logic [15:0] reqAddr,
  input logic        reqAck,
  input logic        rdValid,
  input logic        busy,
  input logic        progError
);

  logic [15:0] runLen;
  logic        mapped;

  assign mapped = ((reqAddr >= BASE_ADDR) &&
                   ({1'b0, reqAddr} < ({1'b0, BASE_ADDR} + 17'(DEPTH_BYTES))))
                  || (reqAddr == CFG_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= '0;
    else       runLen <= busy ? runLen + 1'b1 : '0;
  end

  a_r8_nack_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !reqAck);

  a_r2_unmapped_nack: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp != 2'd2 && !mapped) |-> !reqAck);

  a_r3_rd_follows: assert property (@(posedge clk) disable iff (!rstN)
    (reqAck && reqOp == 2'd0) |=> rdValid);

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    progError |=> progError);

  a_r5_err_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progError) |-> $past(reqAck && reqOp == 2'd1));

  a_r4_busy_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqAck && reqOp != 2'd0));

  a_r8_busy_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == 16'(WR_CYCLES) || runLen == 16'(ERASE_CYCLES)));

endmodule

bind pgerase_nvm nvm_checker #(
  .DEPTH_BYTES (DEPTH_BYTES),
  .BASE_ADDR   (BASE_ADDR),
  .CFG_ADDR    (CFG_ADDR),
  .WR_CYCLES   (WR_CYCLES),
  .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqOp    (reqOp),
  .reqAddr  (reqAddr),
  .reqAck   (reqAck),
  .rdValid  (rdValid),
  .busy     (busy),
  .progError(progError)
);

// File: tb/pgerase_nvm_bench.sv
`timescale 1ns/1ps
module pgerase_nvm_bench;

  localparam int WR  = 16;
  localparam int ER  = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = '0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqData = '0;
  logic        reqAck, rdValid, busy, progError;
  logic [7:0]  rdData;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pgerase_nvm #(.WR_CYCLES(WR), .ERASE_CYCLES(ER)) u_pgerase_nvm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .reqAck(reqAck),
    .rdValid(rdValid), .rdData(rdData), .busy(busy), .progError(progError)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [7:0]  data;
    logic        expAck;
    logic        chkRd;
    logic [7:0]  expRd;
    logic        expErr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 16'hF800, 8'h00, 1'b1, 1'b1, 8'hFF, 1'b0, 4'd1},  // R1 blank low end
    '{2'd0, 16'hF9FF, 8'h00, 1'b1, 1'b1, 8'hFF, 1'b0, 4'd1},  // R1 blank high end
    '{2'd1, 16'hF805, 8'h3C, 1'b1, 1'b0, 8'h00, 1'b0, 4'd4},  // R4 program blank
    '{2'd0, 16'hF805, 8'h00, 1'b1, 1'b1, 8'h3C, 1'b0, 4'd3},  // R3 read back
    '{2'd1, 16'hF805, 8'h55, 1'b1, 1'b0, 8'h00, 1'b1, 4'd5},  // R5 non-blank write
    '{2'd0, 16'hF805, 8'h00, 1'b1, 1'b1, 8'h3C, 1'b1, 4'd5},  // R5 byte kept
    '{2'd2, 16'h0000, 8'hFE, 1'b1, 1'b0, 8'h00, 1'b1, 4'd7},  // R7 erase disabled
    '{2'd0, 16'hF805, 8'h00, 1'b1, 1'b1, 8'h3C, 1'b1, 4'd7},  // R7 not erased
    '{2'd0, 16'h0090, 8'h00, 1'b1, 1'b1, 8'h00, 1'b1, 4'd9},  // R9 cfg reset value
    '{2'd1, 16'h0090, 8'h08, 1'b1, 1'b0, 8'h00, 1'b1, 4'd9},  // R9 set erase enable
    '{2'd0, 16'h0090, 8'h00, 1'b1, 1'b1, 8'h08, 1'b1, 4'd9},  // R9 cfg read back
    '{2'd2, 16'h0000, 8'h5A, 1'b1, 1'b0, 8'h00, 1'b1, 4'd7},  // R7 other command
    '{2'd0, 16'hF805, 8'h00, 1'b1, 1'b1, 8'h3C, 1'b1, 4'd7},  // R7 no effect
    '{2'd1, 16'hF9E0, 8'h12, 1'b1, 1'b0, 8'h00, 1'b1, 4'd4},  // R4 page 15
    '{2'd1, 16'hF83F, 8'hA5, 1'b1, 1'b0, 8'h00, 1'b1, 4'd4},  // R4 page 1
    '{2'd1, 16'hF81F, 8'h11, 1'b1, 1'b0, 8'h00, 1'b1, 4'd4},  // R4 page 0, latch
    '{2'd2, 16'h0000, 8'hFE, 1'b1, 1'b0, 8'h00, 1'b1, 4'd6},  // R6 erase page 0
    '{2'd0, 16'hF805, 8'h00, 1'b1, 1'b1, 8'hFF, 1'b1, 4'd6},  // R6 erased
    '{2'd0, 16'hF81F, 8'h00, 1'b1, 1'b1, 8'hFF, 1'b1, 4'd6},  // R6 page top erased
    '{2'd0, 16'hF83F, 8'h00, 1'b1, 1'b1, 8'hA5, 1'b1, 4'd6},  // R6 page 1 kept
    '{2'd0, 16'hF9E0, 8'h00, 1'b1, 1'b1, 8'h12, 1'b1, 4'd6},  // R6 page 15 kept
    '{2'd0, 16'hF7FF, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 4'd2},  // R2 below range
    '{2'd0, 16'hFA00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 4'd2},  // R2 above range
    '{2'd1, 16'hFA00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 4'd2},  // R2 write above
    '{2'd3, 16'hF800, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 4'd2},  // R2 bad op code
    '{2'd1, 16'hF805, 8'h66, 1'b1, 1'b0, 8'h00, 1'b1, 4'd4},  // R4 reprogram
    '{2'd0, 16'hF805, 8'h00, 1'b1, 1'b1, 8'h66, 1'b1, 4'd4},  // R4 read back
    '{2'd1, 16'hF9FF, 8'h77, 1'b1, 1'b0, 8'h00, 1'b1, 4'd4},  // R4 top byte
    '{2'd0, 16'hF9FF, 8'h00, 1'b1, 1'b1, 8'h77, 1'b1, 4'd4},  // R4 top read
    '{2'd2, 16'h0000, 8'hFE, 1'b1, 1'b0, 8'h00, 1'b1, 4'd6},  // R6 erase page 15
    '{2'd0, 16'hF9E0, 8'h00, 1'b1, 1'b1, 8'hFF, 1'b1, 4'd6},  // R6 page 15 blank
    '{2'd0, 16'hF83F, 8'h00, 1'b1, 1'b1, 8'hA5, 1'b1, 4'd6}   // R6 page 1 kept
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one request; returns ack, read valid and data, busy cycles after accept
  task automatic issue(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d,
                       output logic ack, output logic rv, output logic [7:0] rd,
                       output int busyCnt);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqData = d;
    #1 ack = reqAck;
    @(negedge clk);
    reqValid = 1'b0;
    rv = rdValid; rd = rdData;
    busyCnt = 0;
    while (busy) begin
      busyCnt++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nFail++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic ack, rv;
    logic [7:0] rd;
    int bc;
    string tag;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "busy", busy, 0);
    check("R1", "progError", progError, 0);
    check("R1", "rdValid", rdValid, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      tag = $sformatf("R%0d", VEC[i].req);
      issue(VEC[i].op, VEC[i].addr, VEC[i].data, ack, rv, rd, bc);
      check(tag, $sformatf("vec %0d ack", i), ack, VEC[i].expAck);
      if (VEC[i].chkRd) begin
        check(tag, $sformatf("vec %0d rdValid", i), rv, 1);
        check(tag, $sformatf("vec %0d rdData", i), rd, VEC[i].expRd);
      end
      check(tag, $sformatf("vec %0d progError", i), progError, VEC[i].expErr);
    end

    // R4 exact programming window
    issue(2'd1, 16'hF850, 8'h01, ack, rv, rd, bc);
    check("R4", "program busy length", bc, WR);

    // R8 refusal during programming, refused write leaves byte blank
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd1; reqAddr = 16'hF851; reqData = 8'h02;
    @(negedge clk);
    reqValid = 1'b0;
    check("R4", "busy after blank write", busy, 1);
    reqValid = 1'b1; reqOp = 2'd1; reqAddr = 16'hF860; reqData = 8'h99;
    #1 check("R8", "write ack while busy", reqAck, 0);
    @(negedge clk);
    reqOp = 2'd0; reqAddr = 16'hF851;
    #1 check("R8", "read ack while busy", reqAck, 0);
    @(negedge clk);
    reqValid = 1'b0;
    check("R8", "no rdValid for refused read", rdValid, 0);
    while (busy) @(negedge clk);
    issue(2'd0, 16'hF860, 8'h00, ack, rv, rd, bc);
    check("R8", "refused write had no effect", rd, 8'hFF);
    issue(2'd0, 16'hF851, 8'h00, ack, rv, rd, bc);
    check("R4", "byte programmed after window", rd, 8'h02);

    // R6 exact erase window; latest write was page 2
    issue(2'd2, 16'h0000, 8'hFE, ack, rv, rd, bc);
    check("R6", "erase busy length", bc, ER);
    issue(2'd0, 16'hF850, 8'h00, ack, rv, rd, bc);
    check("R6", "page 2 erased", rd, 8'hFF);

    // R5 sticky until reset, R1 store blank again
    check("R5", "error still set", progError, 1);
    rstN = 1'b0;
    @(negedge clk);
    check("R5", "error cleared by reset", progError, 0);
    rstN = 1'b1;
    issue(2'd0, 16'hF83F, 8'h00, ack, rv, rd, bc);
    check("R1", "store blank after reset", rd, 8'hFF);
    issue(2'd0, 16'h0090, 8'h00, ack, rv, rd, bc);
    check("R1", "cfg zero after reset", rd, 8'h00);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule